// File: doc/BRIEF.md
# Key-Unlocked Protected Register Bank

This block holds a small set of configuration registers for a display pipeline. Most of them feed raster timing and output attributes to logic further down the chip. Some of these registers must not change by accident. A write to one of them takes effect only when the access just before it wrote a fixed key value to a dedicated gate register. The other registers accept writes at any time.

The bank uses a plain memory-mapped port: a byte address, write data, a write strobe, a read strobe and registered read data. The gate opens when the key is written. It stays open for any number of idle cycles. It closes on the very next access of any kind: a read or a write, to any address, mapped or unmapped. All register contents go to downstream logic as one flat bus. Bit 0 of the attribute register also appears as a separate display-enable output. The gate state can be read back, and it is also a port.

Top module: `prot_regbank`

## Requirements
- R1: After reset every register is zero, the gate is closed (`lock_open` = 0), `rd_data` is zero and `display_en` is 0.
- R2: The unguarded registers at byte offsets 0x28, 0x2C, 0x30 and 0x54 take every write, whatever the gate state.
- R3: A write to a guarded register while the gate is closed changes no register. The guarded registers are at 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x24, 0x3C, 0x228 and 0x22C.
- R4: Writing the full data word 0x000000AA to the gate register at offset 0x7C opens the gate. A read of 0x7C returns 1 in bit 0 while the gate is open and 0 while it is closed, with all other bits zero.
- R5: When the gate is open, the next write to a guarded register is stored, and the gate closes in the same cycle.
- R6: The gate stays open through any number of idle cycles. Any read or write other than a key write closes it. This includes an access to an unmapped address and a read of 0x7C itself.
- R7: Writing any value other than 0x000000AA to 0x7C leaves the gate closed, even when it was open. The upper bits are part of the compare.
- R8: `display_en` follows bit 0 of the attribute register at 0x24.
- R9: Read data appears on `rd_data` one clock after the read strobe and holds until the next read. A mapped register returns its contents. Unmapped and unaligned addresses return zero, and writes to them change nothing.
- R10: `regs_q` carries the 16 registers as 32-bit slots in ascending address order, with slot 0 (offset 0x00) in the lowest bits.
- R11: If a read and a write arrive in the same cycle, they count as a single access. The read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (12) | Byte address |
| wr_data | input | DW (32) | Write data |
| rd_data | output | DW (32) | Registered read data |
| regs_q | output | 16*DW | All register contents, slot 0 lowest |
| display_en | output | 1 | Bit 0 of the attribute register |
| lock_open | output | 1 | Gate state, 1 when the next access may modify guarded registers |

## Verification
The bench builds the block with its defaults: a 12-bit byte address, 32-bit data, key 0xAA and the gate register at 0x7C. With a 12-bit address, all 1024 word addresses can be swept twice: once with the gate closed and once right after a key write. This covers every guarded, unguarded, gate and unmapped location against an arithmetic model of the gate. Directed sequences then cover the remaining cases: long idle gaps, relock by reads, near-miss keys, combined read/write cycles and the display-enable bit.

// File: rtl/pbank_pkg.sv
package pbank_pkg;

  // Number of storage slots in the bank
  localparam int NSLOT     = 16;
  // Slot index of the attribute register (display enable in bit 0)
  localparam int ATTR_SLOT = 8;

  // Byte offset of each slot, ascending
  function automatic int unsigned slot_ofs(input int i);
    if (i < 8) return i * 4;
    case (i)
      8:       return 'h24;
      9:       return 'h28;
      10:      return 'h2C;
      11:      return 'h30;
      12:      return 'h3C;
      13:      return 'h54;
      14:      return 'h228;
      default: return 'h22C;
    endcase
  endfunction

  // True for slots whose writes need an open gate
  function automatic logic slot_guarded(input int i);
    return (i <= 8) || (i == 12) || (i >= 14);
  endfunction

  function automatic logic [NSLOT-1:0] guard_mask();
    logic [NSLOT-1:0] m;
    for (int i = 0; i < NSLOT; i++) m[i] = slot_guarded(i);
    return m;
  endfunction

  // Full-word key comparison
  function automatic logic key_match(input logic [63:0] data, input logic [63:0] key);
    return data == key;
  endfunction

endpackage

// File: rtl/pbank_decode.sv
module pbank_decode
  import pbank_pkg::*;
#(
  parameter int          AW       = 12,
  parameter int unsigned LOCK_OFS = 'h7C
) (
  input  logic [AW-1:0]    addr,
  output logic [NSLOT-1:0] slot_sel,
  output logic             hit_lock
);

  for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
    localparam logic [AW-1:0] OFS = AW'(slot_ofs(i));
    assign slot_sel[i] = (addr == OFS);
  end

  assign hit_lock = (addr == AW'(LOCK_OFS));

endmodule

// File: rtl/pbank_keygate.sv
module pbank_keygate (
  input  logic clk,
  input  logic rst_n,
  input  logic access,
  input  logic key_write,
  output logic open_q
);

  // Opened only by a key write, closed by every other access
  always_ff @(posedge clk) begin
    if (!rst_n)      open_q <= 1'b0;
    else if (access) open_q <= key_write;
  end

endmodule

// File: rtl/pbank_slots.sv
module pbank_slots
  import pbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NSLOT-1:0]    slot_we,
  input  logic [DW-1:0]       wr_data,
  output logic [NSLOT*DW-1:0] q_flat
);

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    logic [DW-1:0] r;
    always_ff @(posedge clk) begin
      if (!rst_n)          r <= '0;
      else if (slot_we[i]) r <= wr_data;
    end
    assign q_flat[i*DW +: DW] = r;
  end

endmodule

// File: rtl/pbank_rdport.sv
module pbank_rdport
  import pbank_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [NSLOT-1:0]    slot_sel,
  input  logic                hit_lock,
  input  logic                gate_open,
  input  logic [NSLOT*DW-1:0] q_flat,
  output logic [DW-1:0]       rd_data
);

  logic [DW-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NSLOT; i++)
      if (slot_sel[i]) rd_mux = rd_mux | q_flat[i*DW +: DW];
    if (hit_lock) rd_mux = {{(DW-1){1'b0}}, gate_open};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

endmodule

// File: rtl/prot_regbank.sv
module prot_regbank
  import pbank_pkg::*;
#(
  parameter int            AW       = 12,
  parameter int            DW       = 32,
  parameter logic [DW-1:0] KEY_VAL  = 'hAA,
  parameter int unsigned   LOCK_OFS = 'h7C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wr_data,
  output logic [DW-1:0]       rd_data,
  output logic [NSLOT*DW-1:0] regs_q,
  output logic                display_en,
  output logic                lock_open
);

  localparam logic [NSLOT-1:0] GUARD = guard_mask();

  // Named internal events for the checker
  logic [NSLOT-1:0] slot_sel;
  logic             hit_lock;
  logic             hit_any;
  logic             hit_guarded;
  logic             key_write;
  logic             access;
  logic [NSLOT-1:0] slot_we;

  pbank_decode #(.AW(AW), .LOCK_OFS(LOCK_OFS)) u_dec (
    .addr     (addr),
    .slot_sel (slot_sel),
    .hit_lock (hit_lock)
  );

  assign hit_any     = (|slot_sel) | hit_lock;
  assign hit_guarded = (|(slot_sel & GUARD)) | hit_lock;
  assign key_write   = wr_en & hit_lock & key_match(64'(wr_data), 64'(KEY_VAL));
  assign access      = wr_en | rd_en;
  assign slot_we     = {NSLOT{wr_en}} & slot_sel & (~GUARD | {NSLOT{lock_open}});

  pbank_keygate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .access    (access),
    .key_write (key_write),
    .open_q    (lock_open)
  );

  pbank_slots #(.DW(DW)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_we (slot_we),
    .wr_data (wr_data),
    .q_flat  (regs_q)
  );

  pbank_rdport #(.DW(DW)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .slot_sel  (slot_sel),
    .hit_lock  (hit_lock),
    .gate_open (lock_open),
    .q_flat    (regs_q),
    .rd_data   (rd_data)
  );

  assign display_en = regs_q[ATTR_SLOT*DW];

endmodule

// File: rtl/pbank_chk.sv
module pbank_chk
  import pbank_pkg::*;
#(
  parameter int DW = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [DW-1:0]       rd_data,
  input logic [NSLOT*DW-1:0] regs_q,
  input logic                lock_open,
  input logic                key_write,
  input logic [NSLOT-1:0]    slot_sel,
  input logic                hit_any,
  input logic                hit_guarded,
  input logic                hit_lock
);

  // R6
  relock_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) && !key_write |=> !lock_open);

  // R6
  idle_keeps_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |=> $stable(lock_open));

  // R4
  key_opens_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    key_write |=> lock_open);

  // R3
  locked_write_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hit_guarded && !hit_lock && !lock_open |=> $stable(regs_q));

  // R9
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !hit_any |=> rd_data == '0);

  // R10
  single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));

endmodule

bind prot_regbank pbank_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .rd_data     (rd_data),
  .regs_q      (regs_q),
  .lock_open   (lock_open),
  .key_write   (key_write),
  .slot_sel    (slot_sel),
  .hit_any     (hit_any),
  .hit_guarded (hit_guarded),
  .hit_lock    (hit_lock)
);

// File: tb/sim_prot_regbank.sv
module sim_prot_regbank;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int NS = 16;
  localparam logic [31:0] KEY = 32'hAA;
  localparam logic [11:0] GATE = 12'h07C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NS*DW-1:0] regs_q;
  logic display_en, lock_open;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mdl [0:1023];
  bit m_open;

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_regbank u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .regs_q(regs_q),
    .display_en(display_en), .lock_open(lock_open)
  );

  function automatic bit is_guard(input logic [11:0] a);
    return (a[1:0] == 2'b00 && a <= 12'h01C) ||
           a == 12'h024 || a == 12'h03C || a == 12'h228 || a == 12'h22C;
  endfunction

  function automatic bit is_slot(input logic [11:0] a);
    return is_guard(a) || a == 12'h028 || a == 12'h02C || a == 12'h030 || a == 12'h054;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_write(input logic [11:0] a, input logic [31:0] d);
    if (a == GATE) m_open = (d == KEY);
    else begin
      if (is_slot(a) && (!is_guard(a) || m_open)) mdl[a[11:2]] = d;
      m_open = 0;
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    if (a == GATE) return {31'b0, m_open};
    if (is_slot(a)) return mdl[a[11:2]];
    return 32'h0;
  endfunction

  task automatic bw(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    m_write(a, d);
  endtask

  task automatic br(input logic [11:0] a, input string req);
    logic [31:0] e;
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    e = m_read(a);
    if (a != GATE) m_open = 0; else m_open = 0;
    chk(req, rd_data, e);
  endtask

  task automatic check_outputs(input string req);
    int k = 0;
    for (int a = 0; a <= 'h22C; a += 4) begin
      if (is_slot(12'(a))) begin
        chk(req, regs_q[k*32 +: 32], mdl[a/4]);
        k++;
      end
    end
    chk({req, " display_en R8"}, {31'b0, display_en}, {31'b0, mdl['h24/4][0]});
    chk({req, " lock_open"}, {31'b0, lock_open}, {31'b0, m_open});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] p;
    for (int i = 0; i < 1024; i++) mdl[i] = 0;
    m_open = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_data", rd_data, 0);
    check_outputs("R1 reset");
    br(GATE, "R1 R4 gate reads closed");

    // Sweep with gate closed: R2 R3 R9
    for (int w = 0; w < 1024; w++) begin
      p = 32'h5A000000 ^ (w * 32'h9E3779B1);
      bw(12'(w*4), p);
      br(12'(w*4), "R2 R3 R9 closed sweep");
    end
    check_outputs("R10 after closed sweep");

    // Sweep with key before each write: R5 R4 R7
    for (int w = 0; w < 1024; w++) begin
      p = ~(32'h3C000000 ^ (w * 32'h7F4A7C15));
      bw(GATE, KEY);
      bw(12'(w*4), p);
      br(12'(w*4), "R5 R7 keyed sweep");
    end
    check_outputs("R10 after keyed sweep");

    // R6: gate holds across idle cycles
    bw(GATE, KEY);
    repeat (60) @(negedge clk);
    chk("R6 idle hold", {31'b0, lock_open}, 1);
    bw(12'h014, 32'h1234_5678);
    br(12'h014, "R6 write after idle stored");

    // R6: read of unmapped address relocks
    bw(GATE, KEY);
    br(12'h100, "R6 R9 unmapped read");
    bw(12'h014, 32'hDEAD_0001);
    br(12'h014, "R6 write after relock dropped");

    // R4: gate read shows 1 then 0
    bw(GATE, KEY);
    br(GATE, "R4 gate read open");
    br(GATE, "R4 gate read closed");

    // R7 near-miss keys
    bw(GATE, 32'hAB);
    chk("R7 0xAB", {31'b0, lock_open}, 0);
    bw(GATE, 32'h1AA);
    chk("R7 0x1AA", {31'b0, lock_open}, 0);
    bw(GATE, KEY);
    bw(GATE, 32'h55);
    chk("R7 closes open gate", {31'b0, lock_open}, 0);
    bw(12'h228, 32'hCAFE_F00D);
    br(12'h228, "R7 guarded write after bad key");

    // R8 display enable
    bw(GATE, KEY); bw(12'h024, 32'h1);
    chk("R8 enable set", {31'b0, display_en}, 1);
    bw(GATE, KEY); bw(12'h024, 32'h2);
    chk("R8 enable clear", {31'b0, display_en}, 0);

    // R9 unaligned ignored, rd_data holds
    bw(12'h029, 32'hFFFF_FFFF);
    br(12'h029, "R9 unaligned read zero");
    br(12'h028, "R9 aligned unchanged");
    repeat (5) @(negedge clk);
    chk("R9 rd_data holds", rd_data, mdl['h28/4]);

    // R11 combined read and write
    p = mdl['h054/4];
    @(negedge clk); rd_en = 1; wr_en = 1; addr = 12'h054; wr_data = 32'h0BAD_CAFE;
    @(negedge clk); rd_en = 0; wr_en = 0;
    chk("R11 read returns old", rd_data, p);
    m_write(12'h054, 32'h0BAD_CAFE);
    br(12'h054, "R11 write stored");
    bw(GATE, KEY);
    @(negedge clk); rd_en = 1; wr_en = 1; addr = 12'h03C; wr_data = 32'h0000_0777;
    @(negedge clk); rd_en = 0; wr_en = 0;
    m_write(12'h03C, 32'h0000_0777);
    chk("R11 one access relocks", {31'b0, lock_open}, 0);
    br(12'h03C, "R11 R5 guarded combined stored");
    check_outputs("R10 final");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule